// File: doc/BRIEF.md
# Receiver Event Flag and Interrupt Register

This block keeps a byte-wide register of sticky receiver event flags next to two read-only status fields, together with a byte-wide interrupt enable register and a single registered interrupt line. Hardware sets the event flags from level condition inputs. A wake-up condition, an overrun condition and a receive-buffer-full condition each set their own flag. A fourth flag is set on any change of the receiver or transmitter status fields.

Software reads either register through a combinational read port. It clears a flag by writing a one to that flag's bit. The clear only takes effect when the condition that set the flag is absent in that cycle. If the condition is still asserted, the set wins and the flag stays. The two 2-bit status fields track their hardware inputs with one cycle of latency and cannot be written. The interrupt output is the OR of all enabled flags, registered once.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset both registers read 0x00 and `irqOut` is 0.
- R2: Address 0 is the flag register, laid out as bit 7 wake-up, bit 6 status change, bits 5:4 receiver status, bits 3:2 transmitter status, bit 1 overrun, bit 0 receive-buffer-full. Address 1 is the enable register, whose enables sit at bits 7, 6, 1 and 0, the same positions as the flags they gate.
- R3: A condition input that is high at a rising clock edge sets its flag at that edge. The flag stays set after the condition drops.
- R4: Writing 1 to a flag bit at address 0 clears that flag at the next edge when its condition is low. Writing 0 to a flag bit leaves it unchanged.
- R5: A clear write to a flag whose condition is high in the same cycle is ignored, and the flag stays set.
- R6: The status fields show the values `rxState` and `txState` had at the previous rising edge. Writes to bits 5:2 of address 0 have no effect on them.
- R7: When either status input differs from the stored status field at a rising edge, the status-change flag is set at that edge.
- R8: Writes to address 1 load the four enable bits. Bits 5:2 of the enable register always read 0.
- R9: `irqOut` equals, one cycle later, the OR over the four flags of each flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 1 | Write target: 0 flags, 1 enables |
| wrData | input | 8 | Write data; a 1 at a flag bit requests a clear |
| rdAddr | input | 1 | Read select: 0 flags, 1 enables |
| rdData | output | 8 | Combinational read data |
| wakeCond | input | 1 | Wake-up condition level |
| overrunCond | input | 1 | Overrun condition level |
| rxFullCond | input | 1 | Receive-buffer-full condition level |
| rxState | input | 2 | Receiver status from hardware |
| txState | input | 2 | Transmitter status from hardware |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach from the ports is a clear write that arrives in the very cycle its condition is still asserted, because the write must collide with a live condition at one edge. The bench holds a condition high across the whole write cycle, then drops it and repeats the write. It checks that the flag survives the first write and is cleared by the second. A similar collision is driven for the status-change flag by moving a status input while a clear is pending, so the change pulse and the write meet at one edge.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  localparam int NUM_FLAGS = 4;
  // internal flag index order
  localparam int F_RXFULL  = 0;
  localparam int F_OVERRUN = 1;
  localparam int F_STCHG   = 2;
  localparam int F_WAKE    = 3;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
    logic                 enLoad;
    logic [NUM_FLAGS-1:0] enData;
  } flagStrobe_t;

endpackage

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             wakeCond,
  input  logic             overrunCond,
  input  logic             rxFullCond,
  input  logic             statChange,
  output flagStrobe_t      strb
);

  logic [NUM_FLAGS-1:0] condVec;
  logic [NUM_FLAGS-1:0] wrFlagBits;
  logic                 flagWrite;
  logic                 wrDataUnused;

  assign condVec[F_RXFULL]  = rxFullCond;
  assign condVec[F_OVERRUN] = overrunCond;
  assign condVec[F_STCHG]   = statChange;
  assign condVec[F_WAKE]    = wakeCond;

  // flag bits sit at the two lowest and two highest positions
  assign wrFlagBits   = {wrData[REG_W-1], wrData[REG_W-2], wrData[1], wrData[0]};
  assign wrDataUnused = ^wrData[REG_W-3:2];

  assign flagWrite = wrEn && !wrAddr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      // a live condition blocks the clear: the set wins
      assign strb.setVec[gi] = condVec[gi];
      assign strb.clrVec[gi] = flagWrite && wrFlagBits[gi] && !condVec[gi];
    end
  endgenerate

  assign strb.enLoad = wrEn && wrAddr;
  assign strb.enData = wrFlagBits;

endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
#(
  parameter int STAT_W = 2,
  parameter int REG_W  = 4 + 2 * STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strb,
  input  logic [STAT_W-1:0] rxState,
  input  logic [STAT_W-1:0] txState,
  input  logic              rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              statChange,
  output logic              irqOut
);

  localparam int STATS_W = 2 * STAT_W;

  logic [NUM_FLAGS-1:0] flagReg;
  logic [NUM_FLAGS-1:0] enReg;
  logic [STAT_W-1:0]    rxStatReg;
  logic [STAT_W-1:0]    txStatReg;
  logic [REG_W-1:0]     flagView;
  logic [REG_W-1:0]     enView;

  assign statChange = (rxState != rxStatReg) || (txState != txStatReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg   <= '0;
      enReg     <= '0;
      rxStatReg <= '0;
      txStatReg <= '0;
      irqOut    <= 1'b0;
    end else begin
      flagReg   <= (flagReg & ~strb.clrVec) | strb.setVec;
      rxStatReg <= rxState;
      txStatReg <= txState;
      irqOut    <= |(flagReg & enReg);
      if (strb.enLoad) enReg <= strb.enData;
    end
  end

  assign flagView = {flagReg[F_WAKE], flagReg[F_STCHG], rxStatReg, txStatReg,
                     flagReg[F_OVERRUN], flagReg[F_RXFULL]};
  assign enView   = {enReg[F_WAKE], enReg[F_STCHG], {STATS_W{1'b0}},
                     enReg[F_OVERRUN], enReg[F_RXFULL]};

  assign rdData = rdAddr ? enView : flagView;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagReg & $past(strb.setVec)) == $past(strb.setVec))); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((flagReg | $past(strb.clrVec)) & $past(flagReg)) == $past(flagReg))); // R3

  AST_STATUS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ({rxStatReg, txStatReg} == $past({rxState, txState}))); // R6

  AST_CHANGE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    statChange |=> flagReg[F_STCHG]); // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(flagReg & enReg)))); // R9

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enLoad |=> $stable(enReg)); // R8

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int STAT_W = 2,
  parameter int REG_W  = 4 + 2 * STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              wakeCond,
  input  logic              overrunCond,
  input  logic              rxFullCond,
  input  logic [STAT_W-1:0] rxState,
  input  logic [STAT_W-1:0] txState,
  output logic              irqOut
);

  flagStrobe_t strb;
  logic        statChange;

  irq_flag_ctrl #(.REG_W(REG_W)) u_ctrl (
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .wakeCond    (wakeCond),
    .overrunCond (overrunCond),
    .rxFullCond  (rxFullCond),
    .statChange  (statChange),
    .strb        (strb)
  );

  irq_flag_dp #(.STAT_W(STAT_W), .REG_W(REG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rxState    (rxState),
    .txState    (txState),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .statChange (statChange),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/tb_irq_flag_bank.sv
module tb_irq_flag_bank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       wakeCond = 1'b0;
  logic       overrunCond = 1'b0;
  logic       rxFullCond = 1'b0;
  logic [1:0] rxState = '0;
  logic [1:0] txState = '0;
  logic       irqOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk; // 125 MHz

  irq_flag_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wakeCond(wakeCond),
    .overrunCond(overrunCond), .rxFullCond(rxFullCond),
    .rxState(rxState), .txState(txState), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic addr, output logic [7:0] val);
    rdAddr = addr;
    #1;
    val = rdData;
  endtask

  // write spans one rising edge; returns at the next falling edge
  task automatic writeReg(input logic addr, input logic [7:0] data);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(1'b0, v); check("R1 flags after reset", v, 8'h00);
    readReg(1'b1, v); check("R1 enables after reset", v, 8'h00);
    check("R1 irq after reset", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testSetSticky();
    logic [7:0] v;
    rxFullCond = 1'b1;
    @(negedge clk);
    rxFullCond = 1'b0;
    readReg(1'b0, v); check("R3 rx-full flag set at bit 0", v, 8'h01);
    cycles(3);
    readReg(1'b0, v); check("R3 flag sticky after condition drops", v, 8'h01);
  endtask

  task automatic testClear();
    logic [7:0] v;
    writeReg(1'b0, 8'h00);
    readReg(1'b0, v); check("R4 write of zero leaves flag", v, 8'h01);
    writeReg(1'b0, 8'h01);
    readReg(1'b0, v); check("R4 write-one clears flag", v, 8'h00);
  endtask

  task automatic testBlockedClear();
    logic [7:0] v;
    overrunCond = 1'b1;
    @(negedge clk);
    readReg(1'b0, v); check("R2 overrun flag at bit 1", v, 8'h02);
    writeReg(1'b0, 8'h02);
    readReg(1'b0, v); check("R5 clear ignored while condition high", v, 8'h02);
    overrunCond = 1'b0;
    writeReg(1'b0, 8'h02);
    readReg(1'b0, v); check("R4 clear after condition gone", v, 8'h00);
  endtask

  task automatic testStatus();
    logic [7:0] v;
    rxState = 2'b10;
    @(negedge clk);
    readReg(1'b0, v); check("R6 R7 rx status and change flag", v, 8'h60);
    writeReg(1'b0, 8'hFF);
    readReg(1'b0, v); check("R6 status ignores writes, change flag cleared", v, 8'h20);
    txState = 2'b11;
    @(negedge clk);
    readReg(1'b0, v); check("R7 tx change sets flag", v, 8'h6C);
    // change and clear meet at one edge
    rxState = 2'b01;
    writeReg(1'b0, 8'h40);
    readReg(1'b0, v); check("R5 change pulse beats clear", v, 8'h5C);
    writeReg(1'b0, 8'h40);
    readReg(1'b0, v); check("R4 change flag cleared when steady", v, 8'h1C);
    rxState = 2'b00; txState = 2'b00;
    @(negedge clk);
    writeReg(1'b0, 8'h40);
    readReg(1'b0, v); check("R6 status back to zero", v, 8'h00);
  endtask

  task automatic testEnable();
    logic [7:0] v;
    writeReg(1'b1, 8'hFF);
    readReg(1'b1, v); check("R8 enable readback with reserved zero", v, 8'hC3);
    writeReg(1'b1, 8'h80);
    readReg(1'b1, v); check("R8 enable reload", v, 8'h80);
  endtask

  task automatic testIrq();
    logic [7:0] v;
    wakeCond = 1'b1;
    @(negedge clk);
    wakeCond = 1'b0;
    readReg(1'b0, v); check("R2 wake flag at bit 7", v, 8'h80);
    check("R9 irq lags flag by one cycle", {7'b0, irqOut}, 8'h00);
    @(negedge clk);
    check("R9 irq asserted for enabled flag", {7'b0, irqOut}, 8'h01);
    writeReg(1'b0, 8'h80);
    check("R9 irq held one cycle after clear", {7'b0, irqOut}, 8'h01);
    @(negedge clk);
    check("R9 irq drops after clear", {7'b0, irqOut}, 8'h00);
    overrunCond = 1'b1;
    @(negedge clk);
    overrunCond = 1'b0;
    cycles(2);
    check("R9 disabled flag gives no irq", {7'b0, irqOut}, 8'h00);
    writeReg(1'b1, 8'h02);
    cycles(1);
    check("R9 irq after enabling pending flag", {7'b0, irqOut}, 8'h01);
    writeReg(1'b0, 8'h02);
    writeReg(1'b1, 8'h00);
  endtask

  initial begin
    #100000;
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetSticky();
    testClear();
    testBlockedClear();
    testStatus();
    testEnable();
    testIrq();
    cycles(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule